// File: doc/BRIEF.md
# Eight-Times Oversampled Serial Byte Receiver

This block takes one asynchronous serial line carrying frames of one start bit, eight data bits and one stop bit, and turns them into bytes on a valid/ready stream. The line is timed by a single-cycle enable input, `tick`, which must pulse eight times per bit period. A two-stage synchronizer brings the line into the clock domain. A frame decoder waits for the idle-high line to go low, samples each data bit near the middle of its period, and checks the stop position. Bytes that end with a good stop bit go into an eight-entry FIFO.

A low level at the stop position means a framing error or a break. The byte is discarded, a sticky error flag is raised, and the decoder stays quiet until the line goes high again. A long break therefore never turns into a run of zero bytes. When a byte completes while the FIFO is full, the byte is dropped and a sticky overrun flag is raised. Both flags are plain level outputs, as is a FIFO-not-empty level. One `err_clear` pulse clears both flags.

The read port uses standard valid/ready rules. A byte is removed on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` are held. The FIFO has no other back-pressure path: when the reader stalls long enough for the FIFO to fill, later bytes are lost and flagged as overrun, because the serial line cannot be paused.

Top module: `serial_rx_8x`

## Requirements
- R1: After reset, `out_valid`, `rx_nonempty`, `frame_err` and `overrun_err` are all 0.
- R2: A start is detected on a `tick` where the synchronized line is low while the decoder is idle. The first data bit is sampled on the 11th following tick, each later bit 8 ticks after the previous one, and the stop bit 8 ticks after the last data bit. Reception works for any tick spacing, for example one tick every clock or one tick every third clock.
- R3: Data bits arrive least significant first. The first data bit received appears at `out_data[0]` and the eighth at `out_data[7]`.
- R4: A high level at the stop position places the byte in the FIFO. Bytes leave the FIFO in arrival order.
- R5: A low level at the stop position stores no byte and sets `frame_err`.
- R6: After a stop error, the decoder ignores the line until it has been seen high. A break held low for many bit times yields no bytes, and a correct frame after the line recovers is received normally.
- R7: `frame_err` stays 1 until a cycle with `err_clear` high. If a new error arrives in the same cycle as the clear, the flag stays 1.
- R8: The FIFO holds 8 bytes. A byte that completes while the FIFO is full is dropped and sets the sticky `overrun_err`, which `err_clear` also clears. The 8 stored bytes are not changed.
- R9: A byte is popped on each clock edge with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` do not change.
- R10: While `rx_en` is 0, the decoder is held idle and the line is ignored. A full frame sent during that time produces no byte and no error.
- R11: A `fifo_flush` pulse empties the FIFO. A byte completing in the same cycle is discarded as well.
- R12: `rx_nonempty` is 1 exactly when the FIFO holds at least one byte, which is when `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; 0 holds the decoder idle |
| tick | input | 1 | Oversampling enable, 8 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| err_clear | input | 1 | Clears `frame_err` and `overrun_err` |
| fifo_flush | input | 1 | Empties the receive FIFO |
| out_data | output | 8 | Byte at the head of the FIFO |
| out_valid | output | 1 | Head byte is valid |
| out_ready | input | 1 | Reader accepts the head byte |
| rx_nonempty | output | 1 | FIFO-not-empty level |
| frame_err | output | 1 | Sticky framing or break error |
| overrun_err | output | 1 | Sticky FIFO overrun |

## Verification
The embedded assertions check the rules that must hold on every cycle:
- the FIFO count never goes above its depth;
- the head byte is held under back-pressure;
- a flush leaves the FIFO empty;
- a disabled receiver sits idle;
- the recovery state is held while the line stays low;
- a bad stop raises the error flag, and the flags are sticky.

Correct bit timing and bit order can only be shown by scenarios run over the whole byte space:
- a sweep of all 256 values with a tick on every clock;
- a partial sweep with a tick every third clock.

Break recovery, overrun ordering and the disabled-receiver case are also shown by directed scenarios that compare what comes out of the ports with values computed in the bench.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE    = 2'd0,
    DEC_DATA    = 2'd1,
    DEC_STOP    = 2'd2,
    DEC_RECOVER = 2'd3
  } dec_state_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 tick,
  input  logic                 line_s,
  output logic                 byte_ok,
  output logic                 byte_bad,
  output logic [DATA_BITS-1:0] byte_data
);
  localparam int FIRST_SAMPLE = (TICKS_PER_BIT * 3) / 2 - 1;
  localparam int CW = $clog2(FIRST_SAMPLE + 1);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  dec_state_t           state;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 stop_sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= DEC_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (!rx_en) begin
      state   <= DEC_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      unique case (state)
        DEC_IDLE: begin
          if (tick && !line_s) begin
            state   <= DEC_DATA;
            cnt     <= CW'(FIRST_SAMPLE - 1);
            bit_idx <= '0;
          end
        end
        DEC_DATA: begin
          if (tick) begin
            if (cnt == '0) begin
              shreg <= {line_s, shreg[DATA_BITS-1:1]};
              cnt   <= CW'(TICKS_PER_BIT - 1);
              if (bit_idx == BW'(DATA_BITS - 1)) state <= DEC_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        DEC_STOP: begin
          if (tick) begin
            if (cnt == '0) state <= line_s ? DEC_IDLE : DEC_RECOVER;
            else           cnt   <= cnt - 1'b1;
          end
        end
        DEC_RECOVER: begin
          if (line_s) state <= DEC_IDLE;
        end
        default: state <= DEC_IDLE;
      endcase
    end
  end

  assign stop_sample = rx_en && (state == DEC_STOP) && tick && (cnt == '0);
  assign byte_ok     = stop_sample && line_s;
  assign byte_bad    = stop_sample && !line_s;
  assign byte_data   = shreg;

  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state == DEC_IDLE);
  a_r6_recover_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state == DEC_RECOVER && !line_s) |=> state == DEC_RECOVER);
  a_r6_no_start_from_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DEC_RECOVER) |=> state != DEC_DATA);
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             full,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [NW-1:0]    count;
  logic             do_push, do_pop;

  assign full      = (count == NW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = push && !full && !flush;
  assign do_pop    = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + NW'(do_push) - NW'(do_pop);
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));
  a_r9_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/serial_rx_8x.sv
module serial_rx_8x #(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 8,
  parameter int FIFO_DEPTH    = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 tick,
  input  logic                 rx_line,
  input  logic                 err_clear,
  input  logic                 fifo_flush,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 rx_nonempty,
  output logic                 frame_err,
  output logic                 overrun_err
);
  logic                 line_s;
  logic                 byte_ok, byte_bad, fifo_full;
  logic [DATA_BITS-1:0] byte_data;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  serial_rx_frame #(.DATA_BITS(DATA_BITS), .TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .line_s(line_s),
    .byte_ok(byte_ok), .byte_bad(byte_bad), .byte_data(byte_data)
  );

  serial_rx_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(byte_ok),
    .push_data(byte_data), .full(fifo_full), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      frame_err   <= byte_bad | (frame_err & ~err_clear);
      overrun_err <= (byte_ok & fifo_full & ~fifo_flush) | (overrun_err & ~err_clear);
    end
  end

  assign rx_nonempty = out_valid;

  a_r7_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clear) |=> frame_err);
  a_r5_bad_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    byte_bad |=> frame_err);
  a_r8_full_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && fifo_full && !fifo_flush) |=> overrun_err);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_err && !err_clear) |=> overrun_err);
endmodule

// File: tb/sim_serial_rx_8x.sv
module sim_serial_rx_8x;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       err_clear = 1'b0;
  logic       fifo_flush = 1'b0;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_valid, rx_nonempty, frame_err, overrun_err;

  int tests = 0;
  int fails = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit done = 1'b0;

  serial_rx_8x u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .rx_line(rx_line),
    .err_clear(err_clear), .fifo_flush(fifo_flush), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .rx_nonempty(rx_nonempty),
    .frame_err(frame_err), .overrun_err(overrun_err)
  );

  always #5 clk = ~clk;

  // Tick generator: one pulse every tick_div clocks, changed at negedge.
  initial begin
    forever begin
      @(negedge clk);
      if (tick_cnt + 1 >= tick_div) begin tick_cnt = 0; tick = 1'b1; end
      else begin tick_cnt = tick_cnt + 1; tick = 1'b0; end
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic hold_bit(input logic lvl);
    rx_line = lvl;
    repeat (8 * tick_div) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_lvl);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    hold_bit(stop_lvl);
    hold_bit(1'b1);
  endtask

  task automatic pop_expect(input string req, input int expected);
    int waited = 0;
    while (!out_valid && waited < 2000) begin @(negedge clk); waited++; end
    check(req, int'(out_valid), 1);
    check(req, int'(out_data), expected);
    check("R12", int'(rx_nonempty), int'(out_valid));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse_clear();
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
  endtask

  initial begin
    int limit = 0;
    while (!done && limit < 200000) begin @(posedge clk); limit++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", limit, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0);
    check("R1", int'(rx_nonempty), 0);
    check("R1", int'(frame_err), 0);
    check("R1", int'(overrun_err), 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (20) @(negedge clk);

    // R2 R3 R4: all byte values, tick every clock
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b1);
      pop_expect("R3", v);
    end
    check("R4", int'(frame_err), 0);

    // R2: slower tick, one every third clock
    tick_div = 3;
    for (int v = 0; v < 256; v += 9) begin
      send_frame(8'(v ^ 8'h5A), 1'b1);
      pop_expect("R2", (v ^ 8'h5A) & 255);
    end
    tick_div = 1;
    repeat (20) @(negedge clk);

    // R5: bad stop bit, then line high
    send_frame(8'h3C, 1'b0);
    repeat (20) @(negedge clk);
    check("R5", int'(out_valid), 0);
    check("R5", int'(frame_err), 1);
    // R7: sticky until cleared
    repeat (50) @(negedge clk);
    check("R7", int'(frame_err), 1);
    pulse_clear();
    check("R7", int'(frame_err), 0);

    // R6: long break produces no bytes, then recovery
    rx_line = 1'b0;
    repeat (8 * 20) @(negedge clk);
    check("R6", int'(out_valid), 0);
    check("R6", int'(frame_err), 1);
    rx_line = 1'b1;
    repeat (16) @(negedge clk);
    check("R6", int'(out_valid), 0);
    pulse_clear();
    send_frame(8'hA5, 1'b1);
    pop_expect("R6", 8'hA5);
    check("R6", int'(frame_err), 0);

    // R8: fill 8 without reading, ninth overruns; order kept
    for (int k = 0; k < 9; k++) send_frame(8'(8'h10 + k * 7), 1'b1);
    check("R8", int'(overrun_err), 1);
    // R9: head held while not ready
    check("R9", int'(out_data), 8'h10);
    repeat (10) @(negedge clk);
    check("R9", int'(out_data), 8'h10);
    for (int k = 0; k < 8; k++) pop_expect("R8", 8'h10 + k * 7);
    check("R12", int'(rx_nonempty), 0);
    check("R8", int'(overrun_err), 1);
    pulse_clear();
    check("R8", int'(overrun_err), 0);

    // R10: disabled receiver ignores a full frame
    rx_en = 1'b0;
    send_frame(8'h00, 1'b0);
    send_frame(8'h77, 1'b1);
    check("R10", int'(out_valid), 0);
    check("R10", int'(frame_err), 0);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);
    send_frame(8'hC3, 1'b1);
    pop_expect("R10", 8'hC3);

    // R11: flush empties the FIFO
    for (int k = 0; k < 3; k++) send_frame(8'(k + 1), 1'b1);
    check("R11", int'(out_valid), 1);
    fifo_flush = 1'b1; @(negedge clk); fifo_flush = 1'b0; @(negedge clk);
    check("R11", int'(out_valid), 0);
    check("R11", int'(rx_nonempty), 0);
    send_frame(8'h99, 1'b1);
    pop_expect("R11", 8'h99);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule